// File: doc/BRIEF.md
# PCI Configuration Access Address Engine

This block carries out one PCI configuration-space access per request. A request names a bus, a device, a function, a register offset, a length of 1, 2 or 4 bytes, a direction and, for writes, the data. The engine checks the request and builds the configuration address. It then drives a short fixed sequence of accesses on a simple memory-mapped master port and reports completion with a one-cycle done pulse, an error flag and the read result.

There are two address forms. On bus 0 (type 0), the device is selected by a one-hot bit at position device+16. The bits of that select that fall inside the window mask are loaded into a window register, together with a type-0 code. The remaining select bits go into the issued address. On any other bus (type 1), the window register takes a type-1 code and the address packs bus, device and function into fixed fields. Every accepted access first writes the window register, then reads the configuration word. A write request then stores a word. Sub-word writes merge the new bytes into the word just read. A bus error on that read returns all ones and stops the sequence.

Top module: `cfgAccessEngine`

## Requirements
- R1: `reqReady` is 1 only while the engine is idle; a request is accepted on a clock edge with `reqValid` and `reqReady` both 1, and every accepted request yields exactly one single-cycle `doneValid` pulse, after which `reqReady` returns to 1.
- R2: A request whose `reqLen` is not 1, 2 or 4 completes with `doneErr`=1 and `rspData`=0 and issues no master-port access.
- R3: A request with `cardbusMode`=1 and device above 1, or on bus 0 with device 16 or above, completes with `doneErr`=1 and `rspData`=0 and issues no master-port access.
- R4: The first access of every accepted valid request is a write to `WIN_ADDR`. For bus 0 its data is `TYPE0_CODE` ORed with the bits of (1 << (device+16)) that lie inside `WIN_MASK`.
- R5: For bus 0, the second access is a read at `CFG_BASE` | (select bits outside `WIN_MASK`) | function<<8 | (offset with bits 1:0 cleared).
- R6: For a nonzero bus, the window write carries `TYPE1_CODE`. The read address is `CFG_BASE` | bus<<16 | device<<11 | function<<8 | (offset with bits 1:0 cleared).
- R7: A successful read returns the read word shifted right by 8*(offset mod 4), keeping only the low 8, 16 or 32 bits for length 1, 2 or 4. `doneErr` is 0.
- R8: A successful 1- or 2-byte write stores, at the read address, the read word with the 8 or 16 bits starting at byte lane (offset mod 4) replaced by the low request data bits. Bits shifted past bit 31 are dropped. `rspData`=0 and `doneErr`=0.
- R9: A successful 4-byte write stores `reqWData` unshifted at the read address, after the read.
- R10: If `mBusErr` is 1 on the read access, the request completes with `rspData`=32'hFFFFFFFF and `doneErr`=1, and no store is issued.
- R11: While `mValid` is 1 and `mReady` is 0, `mValid`, `mWrite`, `mAddr` and `mWData` hold their values into the next cycle. An access completes on an edge with both 1, and `mRData`/`mBusErr` are sampled on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cardbusMode | input | 1 | Restricts device numbers to 0 and 1 |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Engine idle, request can be taken |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqBus | input | 8 | Bus number |
| reqDev | input | 5 | Device number |
| reqFunc | input | 3 | Function number |
| reqOff | input | 8 | Register byte offset |
| reqLen | input | 3 | Access length in bytes |
| reqWData | input | 32 | Write data, right aligned |
| doneValid | output | 1 | One-cycle completion pulse |
| doneErr | output | 1 | Request rejected or bus error |
| rspData | output | 32 | Read result, zero or all ones |
| mValid | output | 1 | Master access request |
| mWrite | output | 1 | Master access is a write |
| mAddr | output | 32 | Master access address |
| mWData | output | 32 | Master write data |
| mReady | input | 1 | Slave accepts access this cycle |
| mRData | input | 32 | Slave read data, valid with mReady |
| mBusErr | input | 1 | Slave reports error, valid with mReady |

## Verification
A corrupted select, window split or field packing shows up directly in the window data or read address of the same request, a few cycles after acceptance. A wrong lane mask or shift shows up either in `rspData` on the done pulse or in the store data one access later. A control state that skips, repeats or reorders an access shows up as the wrong access count or order before `doneValid`. A sticky flag shows up as a wrong `doneErr` on the next request. The bench sweeps every device number past both limits, all four byte lanes, all lengths from 0 to 4, both directions, both bus forms, cardbus mode and injected bus errors. It paces the slave so every access also waits one cycle.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

  typedef enum logic [1:0] {
    OP_WIN   = 2'd0,
    OP_PROBE = 2'd1,
    OP_STORE = 2'd2
  } opSelT;

  typedef enum logic [1:0] {
    RES_KEEP = 2'd0,
    RES_ZERO = 2'd1,
    RES_ONES = 2'd2,
    RES_READ = 2'd3
  } resSelT;

  typedef struct packed {
    logic   loadReq;
    logic   loadProbe;
    opSelT  opSel;
    resSelT resSel;
  } strobeT;

  localparam int WORD_W  = 32;
  localparam int LEN_W   = 3;
  localparam int LANES   = WORD_W / 8;

endpackage

// File: rtl/cfgDatapath.sv
module cfgDatapath
  import cfg_pkg::*;
#(
  parameter int BUS_W            = 8,
  parameter int DEV_W            = 5,
  parameter int FUNC_W           = 3,
  parameter int OFF_W            = 8,
  parameter int SLOT_MAX         = 16,
  parameter logic [31:0] CFG_BASE   = 32'h0C00_0000,
  parameter logic [31:0] WIN_ADDR   = 32'h0000_0110,
  parameter logic [31:0] WIN_MASK   = 32'hFC00_0000,
  parameter logic [31:0] TYPE0_CODE = 32'h0000_0002,
  parameter logic [31:0] TYPE1_CODE = 32'h0000_000A
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            stb,
  input  logic              inCardbus,
  input  logic              inWrite,
  input  logic [BUS_W-1:0]  inBus,
  input  logic [DEV_W-1:0]  inDev,
  input  logic [FUNC_W-1:0] inFunc,
  input  logic [OFF_W-1:0]  inOff,
  input  logic [LEN_W-1:0]  inLen,
  input  logic [WORD_W-1:0] inWData,
  input  logic [WORD_W-1:0] mRData,
  output logic              reqBad,
  output logic              isWrite,
  output logic [WORD_W-1:0] mAddr,
  output logic [WORD_W-1:0] mWData,
  output logic [WORD_W-1:0] rspData
);

  localparam logic [DEV_W-1:0] DEV_LIMIT   = DEV_W'(SLOT_MAX);
  localparam logic [DEV_W-1:0] CARDBUS_MAX = DEV_W'(1);
  localparam int               SEL_BASE    = 16;

  logic              cardQ;
  logic              wrQ;
  logic [BUS_W-1:0]  busQ;
  logic [DEV_W-1:0]  devQ;
  logic [FUNC_W-1:0] funcQ;
  logic [OFF_W-1:0]  offQ;
  logic [LEN_W-1:0]  lenQ;
  logic [WORD_W-1:0] wdataQ;
  logic [WORD_W-1:0] probeQ;
  logic [WORD_W-1:0] rspQ;

  // request capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cardQ  <= 1'b0;
      wrQ    <= 1'b0;
      busQ   <= '0;
      devQ   <= '0;
      funcQ  <= '0;
      offQ   <= '0;
      lenQ   <= '0;
      wdataQ <= '0;
    end else if (stb.loadReq) begin
      cardQ  <= inCardbus;
      wrQ    <= inWrite;
      busQ   <= inBus;
      devQ   <= inDev;
      funcQ  <= inFunc;
      offQ   <= inOff;
      lenQ   <= inLen;
      wdataQ <= inWData;
    end
  end

  // request validity
  logic lenBad;
  logic devBad;
  logic isType0;

  always_comb begin
    isType0 = (busQ == '0);
    lenBad  = !((lenQ == 3'd1) || (lenQ == 3'd2) || (lenQ == 3'd4));
    devBad  = (cardQ && (devQ > CARDBUS_MAX)) || (isType0 && (devQ >= DEV_LIMIT));
    reqBad  = lenBad || devBad;
    isWrite = wrQ;
  end

  // address formation
  logic [4:0]        shiftAmt;
  logic [WORD_W-1:0] offAligned;
  logic [WORD_W-1:0] selBit;
  logic [WORD_W-1:0] fieldFunc;
  logic [WORD_W-1:0] winVal;
  logic [WORD_W-1:0] cfgAddr;

  always_comb begin
    shiftAmt   = {offQ[1:0], 3'b000};
    offAligned = WORD_W'(offQ) & ~WORD_W'(3);
    fieldFunc  = WORD_W'(funcQ) << 8;
    if (devQ < DEV_LIMIT) selBit = WORD_W'(1) << (WORD_W'(devQ) + WORD_W'(SEL_BASE));
    else                  selBit = '0;
    if (isType0) begin
      winVal  = TYPE0_CODE | (selBit & WIN_MASK);
      cfgAddr = CFG_BASE | (selBit & ~WIN_MASK) | fieldFunc | offAligned;
    end else begin
      winVal  = TYPE1_CODE;
      cfgAddr = CFG_BASE | (WORD_W'(busQ) << 16) | (WORD_W'(devQ) << 11)
              | fieldFunc | offAligned;
    end
  end

  // probe word held for write merging
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              probeQ <= '0;
    else if (stb.loadProbe) probeQ <= mRData;
  end

  // write merge, one lane per byte
  logic [WORD_W-1:0] shiftedW;
  logic [WORD_W-1:0] mergedW;
  logic [LANES-1:0]  laneOn;

  assign shiftedW = wdataQ << shiftAmt;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    logic [3:0] laneEnd;
    assign laneEnd   = {2'b00, offQ[1:0]} + {1'b0, lenQ};
    assign laneOn[b] = (b >= int'(offQ[1:0])) && (4'(b) < laneEnd);
    assign mergedW[8*b +: 8] = laneOn[b] ? shiftedW[8*b +: 8] : probeQ[8*b +: 8];
  end

  logic [WORD_W-1:0] storeWord;
  assign storeWord = (lenQ == 3'd4) ? wdataQ : mergedW;

  // read alignment
  logic [WORD_W-1:0] shiftedR;
  logic [WORD_W-1:0] readVal;

  always_comb begin
    shiftedR = mRData >> shiftAmt;
    case (lenQ)
      3'd1:    readVal = {24'h0, shiftedR[7:0]};
      3'd2:    readVal = {16'h0, shiftedR[15:0]};
      default: readVal = shiftedR;
    endcase
  end

  // response register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rspQ <= '0;
    else begin
      case (stb.resSel)
        RES_ZERO: rspQ <= '0;
        RES_ONES: rspQ <= '1;
        RES_READ: rspQ <= readVal;
        default:  rspQ <= rspQ;
      endcase
    end
  end

  assign rspData = rspQ;

  // master port data path
  always_comb begin
    case (stb.opSel)
      OP_WIN: begin
        mAddr  = WIN_ADDR;
        mWData = winVal;
      end
      OP_PROBE: begin
        mAddr  = cfgAddr;
        mWData = '0;
      end
      default: begin
        mAddr  = cfgAddr;
        mWData = storeWord;
      end
    endcase
  end

  // R7: a one-byte read result never carries bits above the low byte
  a_r7_byte_read_trunc: assert property (@(posedge clk) disable iff (!rstN)
    (stb.resSel == RES_READ && lenQ == 3'd1) |=> (rspQ[31:8] == 24'h0));

  // R10: an all-ones result is only loaded from the probe step
  a_r10_ones_from_probe: assert property (@(posedge clk) disable iff (!rstN)
    (stb.resSel == RES_ONES) |-> stb.loadProbe);

endmodule

// File: rtl/cfgControl.sv
module cfgControl
  import cfg_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   reqBad,
  input  logic   isWrite,
  input  logic   mReady,
  input  logic   mBusErr,
  output logic   reqReady,
  output logic   mValid,
  output logic   mWrite,
  output logic   doneValid,
  output logic   doneErr,
  output strobeT stb
);

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_DECODE = 3'd1,
    S_WIN    = 3'd2,
    S_PROBE  = 3'd3,
    S_STORE  = 3'd4,
    S_DONE   = 3'd5
  } stateT;

  stateT state, stateNext;
  logic  errQ, errNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      errQ  <= 1'b0;
    end else begin
      state <= stateNext;
      errQ  <= errNext;
    end
  end

  always_comb begin
    stateNext     = state;
    errNext       = errQ;
    stb.loadReq   = 1'b0;
    stb.loadProbe = 1'b0;
    stb.opSel     = OP_WIN;
    stb.resSel    = RES_KEEP;
    reqReady      = 1'b0;
    mValid        = 1'b0;
    mWrite        = 1'b0;
    case (state)
      S_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          stb.loadReq = 1'b1;
          stateNext   = S_DECODE;
        end
      end
      S_DECODE: begin
        if (reqBad) begin
          stb.resSel = RES_ZERO;
          errNext    = 1'b1;
          stateNext  = S_DONE;
        end else begin
          stateNext  = S_WIN;
        end
      end
      S_WIN: begin
        mValid    = 1'b1;
        mWrite    = 1'b1;
        stb.opSel = OP_WIN;
        if (mReady) stateNext = S_PROBE;
      end
      S_PROBE: begin
        mValid    = 1'b1;
        stb.opSel = OP_PROBE;
        if (mReady) begin
          stb.loadProbe = 1'b1;
          if (mBusErr) begin
            stb.resSel = RES_ONES;
            errNext    = 1'b1;
            stateNext  = S_DONE;
          end else if (isWrite) begin
            stateNext  = S_STORE;
          end else begin
            stb.resSel = RES_READ;
            errNext    = 1'b0;
            stateNext  = S_DONE;
          end
        end
      end
      S_STORE: begin
        mValid    = 1'b1;
        mWrite    = 1'b1;
        stb.opSel = OP_STORE;
        if (mReady) begin
          stb.resSel = RES_ZERO;
          errNext    = 1'b0;
          stateNext  = S_DONE;
        end
      end
      S_DONE: begin
        stateNext = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  assign doneValid = (state == S_DONE);
  assign doneErr   = errQ;

  // R1: completion is a single-cycle pulse
  a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  // R1: no new request is taken while a completion is reported
  a_r1_busy_on_done: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> !reqReady);

  // R2 / R3: a rejected request finishes next cycle with the error flag and no access
  a_r2_reject_fast: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DECODE && reqBad) |=> (doneValid && doneErr && !mValid));

  // R4: the access following acceptance is the window write
  a_r4_window_first: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DECODE && !reqBad) |=> (mValid && mWrite && stb.opSel == OP_WIN));

endmodule

// File: rtl/cfgAccessEngine.sv
module cfgAccessEngine
  import cfg_pkg::*;
#(
  parameter int BUS_W            = 8,
  parameter int DEV_W            = 5,
  parameter int FUNC_W           = 3,
  parameter int OFF_W            = 8,
  parameter int SLOT_MAX         = 16,
  parameter logic [31:0] CFG_BASE   = 32'h0C00_0000,
  parameter logic [31:0] WIN_ADDR   = 32'h0000_0110,
  parameter logic [31:0] WIN_MASK   = 32'hFC00_0000,
  parameter logic [31:0] TYPE0_CODE = 32'h0000_0002,
  parameter logic [31:0] TYPE1_CODE = 32'h0000_000A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cardbusMode,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [BUS_W-1:0]  reqBus,
  input  logic [DEV_W-1:0]  reqDev,
  input  logic [FUNC_W-1:0] reqFunc,
  input  logic [OFF_W-1:0]  reqOff,
  input  logic [2:0]        reqLen,
  input  logic [31:0]       reqWData,
  output logic              doneValid,
  output logic              doneErr,
  output logic [31:0]       rspData,
  output logic              mValid,
  output logic              mWrite,
  output logic [31:0]       mAddr,
  output logic [31:0]       mWData,
  input  logic              mReady,
  input  logic [31:0]       mRData,
  input  logic              mBusErr
);

  strobeT stb;
  logic   reqBad;
  logic   isWrite;

  cfgControl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqBad    (reqBad),
    .isWrite   (isWrite),
    .mReady    (mReady),
    .mBusErr   (mBusErr),
    .reqReady  (reqReady),
    .mValid    (mValid),
    .mWrite    (mWrite),
    .doneValid (doneValid),
    .doneErr   (doneErr),
    .stb       (stb)
  );

  cfgDatapath #(
    .BUS_W      (BUS_W),
    .DEV_W      (DEV_W),
    .FUNC_W     (FUNC_W),
    .OFF_W      (OFF_W),
    .SLOT_MAX   (SLOT_MAX),
    .CFG_BASE   (CFG_BASE),
    .WIN_ADDR   (WIN_ADDR),
    .WIN_MASK   (WIN_MASK),
    .TYPE0_CODE (TYPE0_CODE),
    .TYPE1_CODE (TYPE1_CODE)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .inCardbus (cardbusMode),
    .inWrite   (reqWrite),
    .inBus     (reqBus),
    .inDev     (reqDev),
    .inFunc    (reqFunc),
    .inOff     (reqOff),
    .inLen     (reqLen),
    .inWData   (reqWData),
    .mRData    (mRData),
    .reqBad    (reqBad),
    .isWrite   (isWrite),
    .mAddr     (mAddr),
    .mWData    (mWData),
    .rspData   (rspData)
  );

  // R11: a stalled master access holds still
  a_r11_hold_stalled: assert property (@(posedge clk) disable iff (!rstN)
    (mValid && !mReady) |=> (mValid && $stable(mWrite) && $stable(mAddr) && $stable(mWData)));

  // R10: a failed probe read is never followed by a store
  a_r10_no_store_after_err: assert property (@(posedge clk) disable iff (!rstN)
    (mValid && mReady && !mWrite && mBusErr) |=> !mValid);

  // R9: the store of a write always targets the address just probed
  a_r9_store_same_addr: assert property (@(posedge clk) disable iff (!rstN)
    (mValid && mReady && !mWrite && !mBusErr) |=> (!mValid || $stable(mAddr)));

endmodule

// File: tb/tb_cfgAccessEngine.sv
module tb_cfgAccessEngine;

  localparam logic [31:0] CFG_BASE   = 32'h0C00_0000;
  localparam logic [31:0] WIN_ADDR   = 32'h0000_0110;
  localparam logic [31:0] WIN_MASK   = 32'hFC00_0000;
  localparam logic [31:0] TYPE0_CODE = 32'h0000_0002;
  localparam logic [31:0] TYPE1_CODE = 32'h0000_000A;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cardbusMode = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [7:0]  reqBus = '0;
  logic [4:0]  reqDev = '0;
  logic [2:0]  reqFunc = '0;
  logic [7:0]  reqOff = '0;
  logic [2:0]  reqLen = '0;
  logic [31:0] reqWData = '0;
  logic        doneValid;
  logic        doneErr;
  logic [31:0] rspData;
  logic        mValid;
  logic        mWrite;
  logic [31:0] mAddr;
  logic [31:0] mWData;
  logic        mReady = 1'b0;
  logic [31:0] mRData = '0;
  logic        mBusErr = 1'b0;

  always #2.5 clk = ~clk;

  cfgAccessEngine dut (
    .clk(clk), .rstN(rstN), .cardbusMode(cardbusMode),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqBus(reqBus), .reqDev(reqDev), .reqFunc(reqFunc), .reqOff(reqOff),
    .reqLen(reqLen), .reqWData(reqWData),
    .doneValid(doneValid), .doneErr(doneErr), .rspData(rspData),
    .mValid(mValid), .mWrite(mWrite), .mAddr(mAddr), .mWData(mWData),
    .mReady(mReady), .mRData(mRData), .mBusErr(mBusErr)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] slaveWord(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'hC3A5_96E1 ^ (a * 32'd2654435761);
  endfunction

  // slave model and access log, all on the falling edge
  bit          errMode = 1'b0;
  bit          slowTick = 1'b0;
  int          logCnt = 0;
  logic [31:0] logAddr [4];
  logic [31:0] logData [4];
  logic [31:0] logWr   [4];
  bit          pendPrev = 1'b0;
  logic [31:0] prevAddr, prevData;
  logic        prevWr;
  int          holdBad = 0;

  always @(negedge clk) begin
    if (pendPrev && !(mValid && mAddr === prevAddr && mWData === prevData && mWrite === prevWr))
      holdBad++;
    slowTick = ~slowTick;
    mReady   = mValid && slowTick;
    mRData   = slaveWord(mAddr);
    mBusErr  = errMode && mValid && !mWrite;
    if (mValid && mReady && logCnt < 4) begin
      logAddr[logCnt] = mAddr;
      logData[logCnt] = mWData;
      logWr[logCnt]   = {31'h0, mWrite};
      logCnt++;
    end
    pendPrev = mValid && !mReady;
    prevAddr = mAddr;
    prevData = mWData;
    prevWr   = mWrite;
  end

  task automatic runReq(input int bus, input int dev, input int func, input int off,
                        input int len, input bit wr, input bit card, input bit berr);
    logic [31:0] sel, expWin, expAddr, probe, mask, expStore, expRead, wd;
    bit lenOk, devOk, t0;
    int lane;
    string tWin, tAddr;
    wd = 32'hDEAD_BEEF ^ (32'(dev) * 32'h0101_0101) ^ 32'(off);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    logCnt      = 0;
    errMode     = berr;
    cardbusMode = card;
    reqBus      = 8'(bus);
    reqDev      = 5'(dev);
    reqFunc     = 3'(func);
    reqOff      = 8'(off);
    reqLen      = 3'(len);
    reqWrite    = wr;
    reqWData    = wd;
    reqValid    = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    cmp("R1 busy after accept", {31'h0, reqReady}, 32'h0);
    for (int k = 0; k < 40 && !doneValid; k++) @(negedge clk);
    // expected values
    t0    = (bus == 0);
    lane  = off % 4;
    lenOk = (len == 1) || (len == 2) || (len == 4);
    devOk = !(card && dev > 1) && !(t0 && dev >= 16);
    sel   = (t0 && dev < 16) ? (32'h1 << (dev + 16)) : 32'h0;
    if (t0) begin
      expWin  = TYPE0_CODE | (sel & WIN_MASK);
      expAddr = CFG_BASE + (sel & ~WIN_MASK) + (32'(func) * 256) + 32'(off - lane);
      tWin = "R4 window"; tAddr = "R5 addr";
    end else begin
      expWin  = TYPE1_CODE;
      expAddr = CFG_BASE + (32'(bus) * 65536) + (32'(dev) * 2048) + (32'(func) * 256)
              + 32'(off - lane);
      tWin = "R6 window"; tAddr = "R6 addr";
    end
    probe   = slaveWord(expAddr);
    mask    = (len == 1) ? 32'hFF : (len == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
    expRead = (probe >> (8 * lane)) & mask;
    if (len == 4) expStore = wd;
    else expStore = (probe & ~(mask << (8 * lane))) | ((wd << (8 * lane)) & (mask << (8 * lane)));
    cmp("R1 done seen", {31'h0, doneValid}, 32'h1);
    if (!lenOk || !devOk) begin
      cmp(lenOk ? "R3 no access" : "R2 no access", 32'(logCnt), 32'h0);
      cmp(lenOk ? "R3 err"       : "R2 err",       {31'h0, doneErr}, 32'h1);
      cmp(lenOk ? "R3 rsp"       : "R2 rsp",       rspData, 32'h0);
    end else begin
      cmp(tWin, logAddr[0], WIN_ADDR);
      cmp(tWin, logData[0], expWin);
      cmp(tWin, logWr[0], 32'h1);
      cmp(tAddr, logAddr[1], expAddr);
      cmp(tAddr, logWr[1], 32'h0);
      if (berr) begin
        cmp("R10 count", 32'(logCnt), 32'h2);
        cmp("R10 rsp", rspData, 32'hFFFF_FFFF);
        cmp("R10 err", {31'h0, doneErr}, 32'h1);
      end else if (!wr) begin
        cmp("R7 count", 32'(logCnt), 32'h2);
        cmp("R7 rsp", rspData, expRead);
        cmp("R7 err", {31'h0, doneErr}, 32'h0);
      end else begin
        cmp(len == 4 ? "R9 count" : "R8 count", 32'(logCnt), 32'h3);
        cmp(len == 4 ? "R9 addr"  : "R8 addr",  logAddr[2], expAddr);
        cmp(len == 4 ? "R9 data"  : "R8 data",  logData[2], expStore);
        cmp(len == 4 ? "R9 wr"    : "R8 wr",    logWr[2], 32'h1);
        cmp(len == 4 ? "R9 rsp"   : "R8 rsp",   rspData, 32'h0);
        cmp(len == 4 ? "R9 err"   : "R8 err",   {31'h0, doneErr}, 32'h0);
      end
    end
    @(negedge clk);
    cmp("R1 single pulse", {31'h0, doneValid}, 32'h0);
    cmp("R1 ready again", {31'h0, reqReady}, 32'h1);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL R1 watchdog expired actual=running expected=done");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    cmp("R1 reset ready", {31'h0, reqReady}, 32'h1);
    cmp("R1 reset mValid", {31'h0, mValid}, 32'h0);
    cmp("R1 reset done", {31'h0, doneValid}, 32'h0);
    rstN = 1'b1;
    for (int bi = 0; bi < 2; bi++)
      for (int dev = 0; dev < 18; dev++)
        for (int oi = 0; oi < 4; oi++)
          for (int len = 0; len < 5; len++)
            for (int wr = 0; wr < 2; wr++)
              for (int card = 0; card < 2; card++)
                for (int be = 0; be < 2; be++)
                  runReq(bi == 0 ? 0 : 3 + dev, dev, dev % 8, 16 + oi * 17, len,
                         bit'(wr), bit'(card), bit'(be));
    // extra lengths beyond the swept range
    runReq(0, 2, 1, 8'h44, 7, 1'b0, 1'b0, 1'b0);
    runReq(5, 1, 6, 8'hFF, 6, 1'b1, 1'b0, 1'b0);
    cmp("R11 hold while stalled", 32'(holdBad), 32'h0);
    finish();
  end

endmodule